// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Arbiter

This block decides which of ten interrupt vector groups the CPU takes next. Several request lines feed each group, and they are ORed together. Each group carries a one-bit level select. For the first two groups the select chooses between the top level and the bottom level. For the other eight groups it chooses between the middle level and the bottom level.

The arbiter finds the pending group with the greatest level, taking the lowest group index when levels tie. It accepts that group only when its level is strictly above the level now in service. An accepted request pushes its level onto a three-entry in-service stack. A return strobe from the CPU pops the stack, which brings back the level of the interrupted handler. The accept is a single-cycle registered pulse, and the vector address is registered with it.

Requests are level-sensitive. A request that is refused stays pending until its source drops it, and it is reconsidered every cycle.

Top module: `irq_vec_arbiter`

## Requirements
- R1: Levels are encoded in two bits: 0 means none, 1 means low, 2 means high and 3 means top. For groups 0 and 1, select=1 gives top and select=0 gives low. For groups 2 to 9, select=1 gives high and select=0 gives low. The select never raises groups 2 to 9 to top.
- R2: A group is pending when any of its four source bits is set. Source bit s of group g sits at position 4*g+s of the request bus.
- R3: When pending groups differ in level, the one with the greatest level wins, whatever its index.
- R4: When pending groups share the greatest level, the lowest group index wins.
- R5: The vector address of group g is 0x03 + 8*g, so group 0 gives 0x03 and group 9 gives 0x4B.
- R6: A winner whose level is equal to or below the current in-service level is not accepted. It stays pending.
- R7: A winner with a strictly higher level is accepted and its level is pushed. After the push, the in-service level equals the accepted level and the nesting depth rises by one, up to a depth of three.
- R8: A return strobe pops one level, and in that cycle nothing is accepted. A return while the stack is empty leaves the depth at zero.
- R9: While the global enable is low, nothing is accepted.
- R10: After reset the accept output is 0, the depth is 0 and the in-service level is 0. Accept is high for exactly one cycle per accepted request, and the address and level are valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global accept enable |
| src_req | input | 40 | Request sources, four per group |
| lvl_sel | input | 10 | Per-group level select |
| ret_strobe | input | 1 | Return from interrupt; pops one level |
| acc_pulse | output | 1 | One-cycle accept pulse |
| acc_addr | output | 8 | Vector address of the accepted group |
| acc_level | output | 2 | Level of the accepted group |
| svc_level | output | 2 | Level currently in service (0 = none) |
| nest_depth | output | 2 | Number of stacked levels |

## Verification
The bench drives a nest that reaches full depth and then unwinds it. Along the way it offers equal-level and lower-level requests. A design that compared with >= instead of > would accept these and pulse a second time. A request held through a return must be accepted in the cycle after the return and not during it. A design that let the two overlap would corrupt the depth count. Ties between groups 5 and 9, and between groups 7 and 8, expose a scan that favours the wrong end. A low-level group 0 set against a high-level group 7 exposes a scan that weighs index above level. A middle group with its select set must stay at the middle level. Otherwise it would preempt a handler that is running at the same level.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef enum logic [1:0] {
    LV_NONE = 2'd0,
    LV_LOW  = 2'd1,
    LV_HIGH = 2'd2,
    LV_TOP  = 2'd3
  } lvl_t;
endpackage

// File: rtl/irq_lvl_map.sv
module irq_lvl_map
  import irq_arb_pkg::*;
#(
  parameter int NUM_VEC     = 10,
  parameter int SRC_PER_VEC = 4,
  parameter int NUM_TOPCAP  = 2
) (
  input  logic [NUM_VEC*SRC_PER_VEC-1:0] src_req,
  input  logic [NUM_VEC-1:0]             lvl_sel,
  output lvl_t                           vec_lvl [NUM_VEC]
);
  // Each group: OR of its sources, then level from its select.
  for (genvar gv = 0; gv < NUM_VEC; gv++) begin : g_vec
    logic pend;
    assign pend = |src_req[gv*SRC_PER_VEC +: SRC_PER_VEC];
    if (gv < NUM_TOPCAP) begin : g_topcap
      assign vec_lvl[gv] = !pend ? LV_NONE : (lvl_sel[gv] ? LV_TOP : LV_LOW);
    end else begin : g_highcap
      assign vec_lvl[gv] = !pend ? LV_NONE : (lvl_sel[gv] ? LV_HIGH : LV_LOW);
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_arb_pkg::*;
#(
  parameter int NUM_VEC = 10,
  parameter int IDX_W   = 4
) (
  input  lvl_t             vec_lvl [NUM_VEC],
  output logic             win_vld,
  output logic [IDX_W-1:0] win_idx,
  output lvl_t             win_lvl
);
  // Scan from the top index down; >= lets a lower index take an equal level.
  always_comb begin
    win_lvl = LV_NONE;
    win_idx = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (vec_lvl[i] != LV_NONE && vec_lvl[i] >= win_lvl) begin
        win_lvl = vec_lvl[i];
        win_idx = IDX_W'(i);
      end
    end
    win_vld = (win_lvl != LV_NONE);
  end
endmodule

// File: rtl/irq_svc_stack.sv
module irq_svc_stack
  import irq_arb_pkg::*;
#(
  parameter int DEPTH = 3,
  parameter int DEP_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  lvl_t             push_lvl,
  input  logic             pop,
  output lvl_t             top_lvl,
  output logic [DEP_W-1:0] depth
);
  lvl_t stk [DEPTH];

  always_comb begin
    top_lvl = LV_NONE;
    for (int i = 0; i < DEPTH; i++) begin
      if (DEP_W'(i + 1) == depth) top_lvl = stk[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      depth <= '0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= LV_NONE;
    end else if (pop) begin
      if (depth != '0) depth <= depth - 1'b1;
    end else if (push && depth < DEP_W'(DEPTH)) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (DEP_W'(i) == depth) stk[i] <= push_lvl;
      end
      depth <= depth + 1'b1;
    end
  end

  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (rst)
    push |-> depth < DEP_W'(DEPTH)); // R7
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    (pop && depth == '0) |=> depth == '0); // R8
endmodule

// File: rtl/irq_vec_arbiter.sv
module irq_vec_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_VEC     = 10,
  parameter int SRC_PER_VEC = 4,
  parameter int NUM_TOPCAP  = 2,
  parameter int STK_DEPTH   = 3,
  parameter int ADDR_W      = 8,
  parameter int VEC_BASE    = 3,
  parameter int VEC_STEP    = 8,
  localparam int SRC_W      = NUM_VEC * SRC_PER_VEC,
  localparam int DEP_W      = $clog2(STK_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              glb_en,
  input  logic [SRC_W-1:0]  src_req,
  input  logic [NUM_VEC-1:0] lvl_sel,
  input  logic              ret_strobe,
  output logic              acc_pulse,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [1:0]        acc_level,
  output logic [1:0]        svc_level,
  output logic [DEP_W-1:0]  nest_depth
);
  localparam int IDX_W = $clog2(NUM_VEC);

  lvl_t             vec_lvl [NUM_VEC];
  logic             win_vld;
  logic [IDX_W-1:0] win_idx;
  lvl_t             win_lvl;
  lvl_t             top_lvl;
  lvl_t             acc_lvl_q;
  logic             fire;

  irq_lvl_map #(
    .NUM_VEC(NUM_VEC), .SRC_PER_VEC(SRC_PER_VEC), .NUM_TOPCAP(NUM_TOPCAP)
  ) u_map (
    .src_req(src_req), .lvl_sel(lvl_sel), .vec_lvl(vec_lvl)
  );

  irq_pick #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_pick (
    .vec_lvl(vec_lvl), .win_vld(win_vld), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  // Strict preemption; a return cycle accepts nothing.
  assign fire = glb_en && !ret_strobe && win_vld && (win_lvl > top_lvl);

  irq_svc_stack #(.DEPTH(STK_DEPTH), .DEP_W(DEP_W)) u_stk (
    .clk(clk), .rst(rst), .push(fire), .push_lvl(win_lvl),
    .pop(ret_strobe), .top_lvl(top_lvl), .depth(nest_depth)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_pulse <= 1'b0;
      acc_addr  <= '0;
      acc_lvl_q <= LV_NONE;
    end else begin
      acc_pulse <= fire;
      if (fire) begin
        acc_addr  <= ADDR_W'(VEC_BASE + VEC_STEP * int'(win_idx));
        acc_lvl_q <= win_lvl;
      end
    end
  end

  assign acc_level = acc_lvl_q;
  assign svc_level = top_lvl;

  AST_ACK_IS_TOP: assert property (@(posedge clk) disable iff (rst)
    acc_pulse |-> acc_level == svc_level); // R7
  AST_STRICT_RAISE: assert property (@(posedge clk) disable iff (rst)
    acc_pulse |-> acc_level > $past(svc_level)); // R6
  AST_GATED_OFF: assert property (@(posedge clk) disable iff (rst)
    !glb_en |=> !acc_pulse); // R9
  AST_RET_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    ret_strobe |=> !acc_pulse); // R8
  AST_WIN_PENDING: assert property (@(posedge clk) disable iff (rst)
    win_vld |-> |src_req); // R2
endmodule

// File: tb/test_irq_vec_arbiter.sv
module test_irq_vec_arbiter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        glb_en = 1'b0;
  logic [39:0] src_req = '0;
  logic [9:0]  lvl_sel = '0;
  logic        ret_strobe = 1'b0;
  logic        acc_pulse;
  logic [7:0]  acc_addr;
  logic [1:0]  acc_level, svc_level, nest_depth;

  int checks = 0;
  int errors = 0;

  typedef struct {
    bit         ack;
    logic [7:0] addr;
    logic [1:0] lvl;
    logic [1:0] cur;
    logic [1:0] dep;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  irq_vec_arbiter i_irq_vec_arbiter (
    .clk(clk), .rst(rst), .glb_en(glb_en), .src_req(src_req),
    .lvl_sel(lvl_sel), .ret_strobe(ret_strobe), .acc_pulse(acc_pulse),
    .acc_addr(acc_addr), .acc_level(acc_level), .svc_level(svc_level),
    .nest_depth(nest_depth)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic expect_cyc(input bit ack, input int addr, input int lvl,
                            input int cur, input int dep, input string tag);
    exp_t e;
    e.ack = ack; e.addr = 8'(addr); e.lvl = 2'(lvl);
    e.cur = 2'(cur); e.dep = 2'(dep); e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic set_src(input int g, input int s, input bit v);
    src_req[g*4+s] = v;
  endtask

  // Monitor: pops one expected item per cycle, just after the edge.
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk(e.tag, "acc_pulse", int'(acc_pulse), int'(e.ack));
      if (e.ack) begin
        chk(e.tag, "acc_addr", int'(acc_addr), int'(e.addr));
        chk(e.tag, "acc_level", int'(acc_level), int'(e.lvl));
      end
      chk(e.tag, "svc_level", int'(svc_level), int'(e.cur));
      chk(e.tag, "nest_depth", int'(nest_depth), int'(e.dep));
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); expect_cyc(0, 0, 0, 0, 0, "R10 reset");
    // R9: disabled, group 4 pending
    @(negedge clk); set_src(4, 1, 1); expect_cyc(0, 0, 0, 0, 0, "R9 disabled");
    @(negedge clk); glb_en = 1; expect_cyc(1, 'h23, 1, 1, 1, "R5 group4");
    @(negedge clk); expect_cyc(0, 0, 0, 1, 1, "R10 one pulse");
    @(negedge clk); set_src(2, 0, 1); expect_cyc(0, 0, 0, 1, 1, "R6 equal low");
    @(negedge clk); lvl_sel[2] = 1; expect_cyc(1, 'h13, 2, 2, 2, "R1 group2 high");
    @(negedge clk); set_src(0, 2, 1); expect_cyc(0, 0, 0, 2, 2, "R6 lower");
    @(negedge clk); lvl_sel[0] = 1; expect_cyc(1, 'h03, 3, 3, 3, "R7 top nest");
    @(negedge clk); set_src(1, 3, 1); lvl_sel[1] = 1; expect_cyc(0, 0, 0, 3, 3, "R6 equal top");
    @(negedge clk); set_src(0, 2, 0); ret_strobe = 1; expect_cyc(0, 0, 0, 2, 2, "R8 pop");
    @(negedge clk); ret_strobe = 0; expect_cyc(1, 'h0B, 3, 3, 3, "R7 repreempt");
    @(negedge clk); set_src(1, 3, 0); ret_strobe = 1; expect_cyc(0, 0, 0, 2, 2, "R8 pop2");
    @(negedge clk); ret_strobe = 0; set_src(2, 0, 0); expect_cyc(0, 0, 0, 2, 2, "R6 low under high");
    @(negedge clk); ret_strobe = 1; expect_cyc(0, 0, 0, 1, 1, "R8 pop3");
    @(negedge clk); set_src(4, 1, 0); expect_cyc(0, 0, 0, 0, 0, "R8 pop4");
    @(negedge clk); expect_cyc(0, 0, 0, 0, 0, "R8 empty pop");
    @(negedge clk); ret_strobe = 0; lvl_sel = '0; set_src(9, 3, 1); set_src(5, 0, 1);
    expect_cyc(1, 'h2B, 1, 1, 1, "R4 tie 5v9");
    @(negedge clk); set_src(5, 0, 0); ret_strobe = 1; expect_cyc(0, 0, 0, 0, 0, "R8 pop5");
    @(negedge clk); ret_strobe = 0; expect_cyc(1, 'h4B, 1, 1, 1, "R5 group9");
    @(negedge clk); set_src(9, 3, 0); ret_strobe = 1; expect_cyc(0, 0, 0, 0, 0, "R8 pop6");
    @(negedge clk); ret_strobe = 0; set_src(0, 1, 1); set_src(7, 2, 1); lvl_sel[7] = 1;
    expect_cyc(1, 'h3B, 2, 2, 1, "R3 level over index");
    @(negedge clk); expect_cyc(0, 0, 0, 2, 1, "R3 low held");
    @(negedge clk); set_src(8, 0, 1); lvl_sel[8] = 1; expect_cyc(0, 0, 0, 2, 1, "R1 group8 capped high");
    @(negedge clk); glb_en = 0; ret_strobe = 1; expect_cyc(0, 0, 0, 0, 0, "R8 pop7");
    @(negedge clk); ret_strobe = 0; expect_cyc(0, 0, 0, 0, 0, "R9 disabled pending");
    @(negedge clk); glb_en = 1; expect_cyc(1, 'h3B, 2, 2, 1, "R4 tie 7v8");
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule